// File: doc/BRIEF.md
# Converter Engine Register Block

This block is the software-visible register file of one analog converter engine. It holds control, interrupt, detect and clock settings, packed per-pair sample words, per-channel window limits, per-channel hysteresis settings, an interrupt source word and a trimming field. Every write is filtered through a per-register mask. The analog conversion is not part of the block: sample words are loaded by software and then advanced by a synthetic step generator.

Reading a sample word has side effects. The block returns the word as it stood, then advances the even channel by one step and the odd channel by another, and compares both advanced values against their windows. A channel outside its window latches a pending bit for that pair, and that bit drives a level interrupt until software writes it back to zero.

The channel count is a parameter (8 or 16). With 8 channels, the upper half of the sample, limit and hysteresis spaces is rejected. The bus is a single-cycle request port with byte addresses and word-aligned registers. Read data is registered.

Top module: `adc_engine_regs`

## Requirements
- R1: After reset, engine control (0x00) and interrupt control (0x04) read 0, detect control (0x08) and clock control (0x0C) read 0x0000000F, and irq_o is low.
- R2: Register offsets: 0x00 engine control, 0x04 interrupt control, 0x08 detect control, 0x0C clock control, 0x10+4p sample word of pair p, 0x30+4c window limits of channel c, 0x70+4c hysteresis of channel c, 0xC0 interrupt source, 0xC4 trimming.
- R3: A write to engine control stores bit 8 equal to written bit 0 and bit 5 as zero. All other bits are stored as written (mode in bits 3:1, channel enables in bits 31:16).
- R4: Write masks: sample and limit words keep 0x03FF03FF, hysteresis keeps 0x83FF03FF, interrupt source keeps 0x0000FFFF and trimming keeps 0x0000000F. Interrupt, detect and clock control keep all 32 bits.
- R5: A packed word has the even channel in bits 9:0 and the odd channel in bits 25:16. A limit word has the lower limit in bits 9:0 and the upper limit in bits 25:16. A sample read returns the current word, after which the even field adds 5 and the odd field adds 7, each modulo 1024.
- R6: After a sample read, if either advanced value of pair p is strictly below that channel's lower limit or strictly above its upper limit, bit p of interrupt control is set. A value equal to a limit does not set it.
- R7: irq_o is high exactly while any of bits 7:0 of interrupt control is set. Writing those bits to zero lowers it.
- R8: With NUM_CH = 8, sample words at 0x20 and above, limits at 0x50 and above and hysteresis at 0x90 and above are rejected. Their reads return 0, their writes change no register, and reading them sets no pending bit.
- R9: A read with half_i high of a sample word returns bits 31:16 in rdata_o[15:0] when address bit 1 is set, and bits 15:0 when it is clear. rdata_o[31:16] is 0 in both cases.
- R10: Reads of unmapped offsets return 0, and writes to them change no register and leave irq_o unchanged.
- R11: Read data appears on rdata_o on the clock edge that accepts the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| half_i | input | 1 | 16-bit read of a sample word |
| addr_i | input | 8 | Byte address, bits 1:0 only select the halfword |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, any pending pair |

## Verification
The hardest situation to reach is a window trip on a chosen channel at a known read. The pending bit depends on the advanced value rather than the returned one, and on limits that reset to zero. The bench first loads limits so that every unused channel is inside its window. It then loads a sample word a fixed number of steps away from a limit and counts reads until the value lands exactly on the limit (no trip) and then one step past it (trip). It does this separately for the lower limit, the upper limit and the odd channel. An 8-channel and a 16-channel instance share the bus, so the same access shows both the rejected and the accepted behaviour, including a pending bit raised only in the larger instance.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam int VAL_W = 10;
  localparam int STEP_LO = 5;
  localparam int STEP_HI = 7;

  localparam logic [5:0] IDX_CTRL  = 6'd0;
  localparam logic [5:0] IDX_INTC  = 6'd1;
  localparam logic [5:0] IDX_DET   = 6'd2;
  localparam logic [5:0] IDX_CLK   = 6'd3;
  localparam logic [5:0] IDX_DATA0 = 6'd4;
  localparam logic [5:0] IDX_BND0  = 6'd12;
  localparam logic [5:0] IDX_HYS0  = 6'd28;
  localparam logic [5:0] IDX_SRC   = 6'd48;
  localparam logic [5:0] IDX_TRIM  = 6'd49;

  localparam logic [31:0] MSK_HYS  = 32'h83FF_03FF;
  localparam logic [31:0] MSK_SRC  = 32'h0000_FFFF;
  localparam logic [31:0] MSK_TRIM = 32'h0000_000F;
  localparam logic [31:0] RST_DET  = 32'h0000_000F;
  localparam logic [31:0] RST_CLK  = 32'h0000_000F;

  typedef struct packed {
    logic [VAL_W-1:0] hi;
    logic [VAL_W-1:0] lo;
  } pair_t;

  function automatic logic [31:0] pack_pair(pair_t p);
    return {{(16-VAL_W){1'b0}}, p.hi, {(16-VAL_W){1'b0}}, p.lo};
  endfunction

  function automatic pair_t unpack_pair(logic [31:0] w);
    pair_t p;
    p.lo = w[VAL_W-1:0];
    p.hi = w[16+VAL_W-1:16];
    return p;
  endfunction
endpackage

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
  parameter int W = 10
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         out_o
);
  assign out_o = (val_i < lo_i) || (val_i > hi_i);
endmodule

// File: rtl/adc_pair_unit.sv
module adc_pair_unit
  import adc_regs_pkg::*;
#(
  parameter int STEP_L = STEP_LO,
  parameter int STEP_H = STEP_HI
) (
  input  pair_t cur_i,
  input  pair_t bnd_even_i,
  input  pair_t bnd_odd_i,
  output pair_t nxt_o,
  output logic  trip_o
);
  logic out_even, out_odd;

  // fields wrap naturally at VAL_W bits
  assign nxt_o.lo = cur_i.lo + VAL_W'(STEP_L);
  assign nxt_o.hi = cur_i.hi + VAL_W'(STEP_H);

  adc_window_cmp #(.W(VAL_W)) u_cmp_even (
    .val_i(nxt_o.lo), .lo_i(bnd_even_i.lo), .hi_i(bnd_even_i.hi), .out_o(out_even)
  );
  adc_window_cmp #(.W(VAL_W)) u_cmp_odd (
    .val_i(nxt_o.hi), .lo_i(bnd_odd_i.lo), .hi_i(bnd_odd_i.hi), .out_o(out_odd)
  );

  assign trip_o = out_even | out_odd;
endmodule

// File: rtl/adc_engine_regs.sv
module adc_engine_regs
  import adc_regs_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        half_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int PW = $clog2(NUM_PAIR);
  localparam int CW = $clog2(NUM_CH);

  logic [31:0] ctrl_q, intc_q, det_q, clk_q;
  logic [15:0] src_q;
  logic [3:0]  trim_q;
  pair_t       data_q [NUM_PAIR];
  pair_t       bnd_q  [NUM_CH];
  logic [31:0] hys_q  [NUM_CH];

  pair_t       nxt    [NUM_PAIR];
  logic [NUM_PAIR-1:0] trip;

  logic [5:0]  idx, off_d, off_b, off_h;
  logic        sel_data, sel_bnd, sel_hys;
  logic [PW-1:0] psel;
  logic [CW-1:0] bsel, hsel;
  logic [31:0] rd_val, ctrl_wr;

  assign idx   = addr_i[7:2];
  assign off_d = idx - IDX_DATA0;
  assign off_b = idx - IDX_BND0;
  assign off_h = idx - IDX_HYS0;
  assign sel_data = (idx >= IDX_DATA0) && (off_d < 6'(NUM_PAIR));
  assign sel_bnd  = (idx >= IDX_BND0)  && (off_b < 6'(NUM_CH));
  assign sel_hys  = (idx >= IDX_HYS0)  && (off_h < 6'(NUM_CH));
  assign psel = off_d[PW-1:0];
  assign bsel = off_b[CW-1:0];
  assign hsel = off_h[CW-1:0];

  // init-done mirrors enable, auto-compensation always cleared
  assign ctrl_wr = {wdata_i[31:9], wdata_i[0], wdata_i[7:6], 1'b0, wdata_i[4:0]};

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    adc_pair_unit u_pair (
      .cur_i     (data_q[p]),
      .bnd_even_i(bnd_q[2*p]),
      .bnd_odd_i (bnd_q[2*p+1]),
      .nxt_o     (nxt[p]),
      .trip_o    (trip[p])
    );
  end

  always_comb begin
    rd_val = '0;
    if (idx == IDX_CTRL)      rd_val = ctrl_q;
    else if (idx == IDX_INTC) rd_val = intc_q;
    else if (idx == IDX_DET)  rd_val = det_q;
    else if (idx == IDX_CLK)  rd_val = clk_q;
    else if (idx == IDX_SRC)  rd_val = {16'b0, src_q};
    else if (idx == IDX_TRIM) rd_val = {28'b0, trim_q};
    else if (sel_data) begin
      rd_val = pack_pair(data_q[psel]);
      if (half_i) rd_val = addr_i[1] ? {16'b0, rd_val[31:16]} : {16'b0, rd_val[15:0]};
    end
    else if (sel_bnd)  rd_val = pack_pair(bnd_q[bsel]);
    else if (sel_hys)  rd_val = hys_q[hsel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      intc_q  <= '0;
      det_q   <= RST_DET;
      clk_q   <= RST_CLK;
      src_q   <= '0;
      trim_q  <= '0;
      rdata_o <= '0;
      for (int i = 0; i < NUM_PAIR; i++) data_q[i] <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        bnd_q[i] <= '0;
        hys_q[i] <= '0;
      end
    end else if (req_i) begin
      if (we_i) begin
        if (idx == IDX_CTRL)      ctrl_q <= ctrl_wr;
        else if (idx == IDX_INTC) intc_q <= wdata_i;
        else if (idx == IDX_DET)  det_q  <= wdata_i;
        else if (idx == IDX_CLK)  clk_q  <= wdata_i;
        else if (idx == IDX_SRC)  src_q  <= wdata_i[15:0] & MSK_SRC[15:0];
        else if (idx == IDX_TRIM) trim_q <= wdata_i[3:0] & MSK_TRIM[3:0];
        else if (sel_data) data_q[psel] <= unpack_pair(wdata_i);
        else if (sel_bnd)  bnd_q[bsel]  <= unpack_pair(wdata_i);
        else if (sel_hys)  hys_q[hsel]  <= wdata_i & MSK_HYS;
      end else begin
        rdata_o <= rd_val;
        if (sel_data) begin
          data_q[psel] <= nxt[psel];
          if (trip[psel]) intc_q[psel] <= 1'b1;
        end
      end
    end
  end

  assign irq_o = |intc_q[7:0];
endmodule

// File: rtl/adc_engine_regs_chk.sv
module adc_engine_regs_chk #(
  parameter int NUM_CH = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic        wdata_b0_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic [31:0] ctrl_q
);
  logic [5:0] idx;
  logic unmapped, rejected, irq_src;
  assign idx = addr_i[7:2];
  assign unmapped = (idx >= 6'd44 && idx <= 6'd47) || (idx >= 6'd50);
  assign rejected = (NUM_CH == 8) &&
                    ((idx >= 6'd8 && idx <= 6'd11) || (idx >= 6'd20 && idx <= 6'd27) ||
                     (idx >= 6'd36 && idx <= 6'd43));
  assign irq_src = req_i && (we_i ? (idx == 6'd1) : (idx >= 6'd4 && idx <= 6'd11));

  a_r3_ctrl_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == 6'd0) |=> (ctrl_q[8] == $past(wdata_b0_i)) && !ctrl_q[5]);

  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(req_i && we_i && idx == 6'd1)) |=> irq_o);

  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_src));

  a_r10_unmapped_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |=> rdata_o == 32'h0);

  a_r10_unmapped_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && unmapped) |=> $stable(irq_o));

  a_r8_rejected_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && rejected) |=> rdata_o == 32'h0);
endmodule

bind adc_engine_regs adc_engine_regs_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_b0_i(wdata_i[0]), .rdata_o(rdata_o), .irq_o(irq_o), .ctrl_q(ctrl_q)
);

// File: tb/adc_engine_regs_tb_top.sv
`timescale 1ns/1ps
module adc_engine_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, half = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd16, rd8;
  logic irq16, irq8;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_engine_regs #(.NUM_CH(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .half_i(half),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd16), .irq_o(irq16));
  adc_engine_regs #(.NUM_CH(8)) dut8_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .half_i(half),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd8), .irq_o(irq8));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; half = 0; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic h);
    @(negedge clk);
    req = 1; we = 0; half = h; addr = a;
    @(negedge clk);
    req = 0; half = 0;
  endtask

  task automatic t_reset;
    rd(8'h00, 0); chk("R1 ctrl", rd16, 0);
    rd(8'h04, 0); chk("R1 intc", rd16, 0);
    rd(8'h08, 0); chk("R1 det", rd16, 32'hF);
    rd(8'h0C, 0); chk("R1 clk", rd16, 32'hF);
    chk("R1 irq", {31'b0, irq16}, 0);
  endtask

  task automatic t_ctrl;
    wr(8'h00, 32'h0001_0021); rd(8'h00, 0); chk("R3 enable on", rd16, 32'h0001_0101);
    wr(8'h00, 32'h0000_010E); rd(8'h00, 0); chk("R3 enable off", rd16, 32'h0000_000E);
  endtask

  task automatic t_masks;
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, 0); chk("R4 limit mask", rd16, 32'h03FF_03FF);
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, 0); chk("R4 hyst mask", rd16, 32'h83FF_03FF);
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, 0); chk("R4 src mask", rd16, 32'h0000_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF); rd(8'hC4, 0); chk("R4 trim mask", rd16, 32'h0000_000F);
    wr(8'h08, 32'h1234_5678); rd(8'h08, 0); chk("R2 det", rd16, 32'h1234_5678);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, 0); chk("R2 clk", rd16, 32'hFFFF_FFFF);
  endtask

  task automatic t_sample;
    wr(8'h30, 32'h03FF_0000); wr(8'h34, 32'h03FF_0000);
    wr(8'h10, 32'h0064_0032);
    rd(8'h10, 0); chk("R11 first read", rd16, 32'h0064_0032);
    rd(8'h10, 0); chk("R5 step", rd16, 32'h006B_0037);
    wr(8'h10, 32'h03FE_03FD);
    rd(8'h10, 0); rd(8'h10, 0); chk("R5 wrap", rd16, 32'h0005_0002);
    chk("R6 no trip in window", {31'b0, irq16}, 0);
  endtask

  task automatic t_window;
    wr(8'h38, 32'h0014_000A); wr(8'h3C, 32'h03FF_0000);
    wr(8'h14, 32'h0000_0005);
    rd(8'h14, 0); rd(8'h14, 0); rd(8'h14, 0); // advanced lower reaches 20 = upper limit
    chk("R6 equal limit no trip", {31'b0, irq16}, 0);
    rd(8'h14, 0); // 25 > 20
    chk("R6 above trips", {31'b0, irq16}, 1);
    rd(8'h04, 0); chk("R6 pair1 bit", rd16, 32'h2);
    wr(8'h04, 0); chk("R7 clear", {31'b0, irq16}, 0);
    wr(8'h40, 32'h00C8_0064); wr(8'h44, 32'h03FF_0000);
    wr(8'h18, 32'h0000_005A);
    rd(8'h18, 0); rd(8'h04, 0); chk("R6 below trips pair2", rd16, 32'h4);
    chk("R7 irq high", {31'b0, irq16}, 1);
    wr(8'h04, 0);
    wr(8'h48, 32'h03FF_0000); wr(8'h4C, 32'h000A_0000);
    wr(8'h1C, 32'h0005_0000);
    rd(8'h1C, 0); rd(8'h04, 0); chk("R6 odd channel pair3", rd16, 32'h8);
    wr(8'h04, 0); chk("R7 clear again", {31'b0, irq16}, 0);
  endtask

  task automatic t_half;
    wr(8'h10, 32'h0123_0045);
    rd(8'h12, 1); chk("R9 upper half", rd16, 32'h0000_0123);
    rd(8'h10, 1); chk("R9 lower half", rd16, 32'h0000_004A);
    rd(8'h10, 0); chk("R9 full after halves", rd16, 32'h0131_004F);
  endtask

  task automatic t_rejected;
    wr(8'h50, 32'h00AA_00BB);
    rd(8'h50, 0); chk("R8 limit 16ch", rd16, 32'h00AA_00BB); chk("R8 limit 8ch", rd8, 0);
    rd(8'h30, 0); chk("R8 alias untouched", rd8, 32'h03FF_0000);
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, 0); chk("R8 hyst 16ch", rd16, 32'h83FF_03FF); chk("R8 hyst 8ch", rd8, 0);
    rd(8'h70, 0); chk("R8 hyst alias", rd8, 32'h83FF_03FF);
    wr(8'h20, 32'h0011_0022);
    rd(8'h20, 0); chk("R8 data 16ch", rd16, 32'h0011_0022); chk("R8 data 8ch", rd8, 0);
    chk("R8 16ch trips pair4", {31'b0, irq16}, 1);
    chk("R8 8ch no trip", {31'b0, irq8}, 0);
    rd(8'h10, 0); chk("R8 alias data", rd8, 32'h0138_0054);
    wr(8'h04, 0);
  endtask

  task automatic t_unmapped;
    wr(8'hB0, 32'hFFFF_FFFF);
    rd(8'hB0, 0); chk("R10 unmapped read", rd16, 0);
    rd(8'hC8, 0); chk("R10 unmapped read hi", rd16, 0);
    chk("R10 irq unchanged", {31'b0, irq16}, 0);
    rd(8'h04, 0); chk("R10 intc unchanged", rd16, 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_masks();
    t_sample();
    t_window();
    t_half();
    t_rejected();
    t_unmapped();
    summary();
  end
endmodule